// File: doc/BRIEF.md
# Rotating-Priority Shared Bus Arbiter

This block decides which master owns a shared external bus. Up to `NUM_PEERS` peer processors each present a request line and receive a one-hot grant. A host processor has its own request input and a separate grant output. Among the peers, priority rotates. The search for the next owner starts one position past the peer that last gave the bus up, so a recent owner waits behind everyone else.

An owner keeps the bus while it holds its request or its lock line. The lock line protects atomic read-modify-write sequences from both rotation and the fairness cap. The fairness cap is a run-time cycle limit. Once the owner has held the bus for that many cycles and any other master is waiting, ownership moves on, unless the owner is locked. The host is served at the first arbitration point after a peer tenure ends. A back-off input lets the host take the bus from a locked peer immediately, which recovers from deadlock. Grants are registered, and a hand-over happens on a single clock edge with no idle cycle.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is held and right after it, neither grant output is active. The rotation pointer starts at peer 0, so the first arbitration with every peer requesting grants peer 0 (peer_gnt = 8'h01).
- R2: In every cycle, at most one bit across {host_gnt, peer_gnt} is high.
- R3: A grant is issued only to a master whose request was high in the cycle before the grant appears. When no master requests, both grant outputs go low one cycle after the owner releases.
- R4: When a peer releases, the next search runs upward from that peer's index plus one and wraps from NUM_PEERS-1 back to 0.
- R5: A peer owner keeps its grant while either peer_req or peer_lock at its index is high. It releases on the edge after both are low.
- R6: With tenure_limit = L > 0, a peer that has shown its grant for L cycles loses it on the next edge if another peer or the host is requesting and its lock is low. The search then starts one past that peer.
- R7: When tenure_limit is 0, the fairness cap is disabled and an owner is never preempted by time.
- R8: When no other master requests, an owner is not preempted, however long it holds the bus.
- R9: While the owner's peer_lock is high, the fairness cap does not remove its grant.
- R10: With HOST_FIRST set, a requesting host wins over peers at every arbitration point. The host keeps host_gnt until host_req falls, and the fairness cap never applies to the host.
- R11: When host_boff and host_req are both high while a peer owns the bus, host_gnt is active after the next edge, even if that peer is locked.
- R12: A host tenure does not move the rotation pointer. After the host releases, peer search resumes where it left off.
- R13: Release and new grant happen on the same edge: the outgoing and incoming grants are in adjacent cycles with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| peer_req | input | NUM_PEERS | Bus request from each peer |
| peer_lock | input | NUM_PEERS | Lock line from each peer; only the owner's bit matters |
| host_req | input | 1 | Bus request from the host |
| host_boff | input | 1 | Host back-off: forces the peer owner off the bus |
| tenure_limit | input | TENURE_W | Fairness cap in cycles; 0 disables it |
| peer_gnt | output | NUM_PEERS | One-hot grant to peers |
| host_gnt | output | 1 | Grant to the host |

## Verification
The bench aims at the rotation wrap from the top index to peer 0. An arbiter that restarted at a fixed priority would grant peer 0 too early, or starve high indices. It counts the exact fairness cut-off, so an off-by-one counter would show one grant cycle too many or too few. It also checks that an idle owner with nobody waiting is never cut off. Locked owners are driven with waiting masters present, to catch a cap that ignores the lock. A back-off against a locked owner must still hand the bus to the host, and a stuck arbiter would keep the peer granted. After a long host tenure, the bench checks that peer rotation resumes from the saved pointer and not from wherever the host left it.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_PEER = 2'd1,
        OWN_HOST = 2'd2
    } bus_own_e;

endpackage

// File: rtl/bus_arb_rr_pick.sv
module bus_arb_rr_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] start,
    output logic [IW-1:0] sel,
    output logic          found
);
    // First candidate at or after start, wrapping at N.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!found && cand[(int'(start) + k) % N]) begin
                found = 1'b1;
                sel   = IW'((int'(start) + k) % N);
            end
        end
    end
endmodule

// File: rtl/bus_arb_tenure.sv
module bus_arb_tenure #(
    parameter int TW = 8
) (
    input  logic [TW-1:0] cnt_q,
    input  logic [TW-1:0] limit,
    input  logic          restart,
    input  logic          hold,
    output logic [TW-1:0] cnt_d,
    output logic          expired
);
    always_comb begin
        if (restart)
            cnt_d = TW'(1);
        else if (hold && (cnt_q != '1))
            cnt_d = cnt_q + TW'(1);
        else
            cnt_d = cnt_q;
    end

    // Limit of zero turns the cap off.
    assign expired = (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import bus_arb_pkg::*;
#(
    parameter int NUM_PEERS  = 8,
    parameter int TENURE_W   = 8,
    parameter bit HOST_FIRST = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PEERS-1:0] peer_req,
    input  logic [NUM_PEERS-1:0] peer_lock,
    input  logic                 host_req,
    input  logic                 host_boff,
    input  logic [TENURE_W-1:0]  tenure_limit,
    output logic [NUM_PEERS-1:0] peer_gnt,
    output logic                 host_gnt
);
    localparam int IW = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_PEERS - 1);

    typedef struct packed {
        bus_own_e      own;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
        logic [TENURE_W-1:0] cnt;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic                 peer_active, host_active;
    logic [NUM_PEERS-1:0] owner_oh, cand;
    logic                 others_wait, boff_hit, owner_keep, owner_locked;
    logic                 expired, peer_release, host_release, bus_free;
    logic                 host_wins, found, restart, hold;
    logic [IW-1:0]        next_after, pick_start, sel;
    logic [TENURE_W-1:0]  cnt_d;

    assign peer_active  = (state_q.own == OWN_PEER);
    assign host_active  = (state_q.own == OWN_HOST);

    always_comb begin
        owner_oh = '0;
        if (peer_active)
            owner_oh[state_q.owner] = 1'b1;
    end

    assign owner_keep   = peer_req[state_q.owner] | peer_lock[state_q.owner];
    assign owner_locked = peer_lock[state_q.owner];
    assign others_wait  = host_req | (|(peer_req & ~owner_oh));
    assign boff_hit     = host_boff & host_req & peer_active;
    assign peer_release = peer_active &
                          (boff_hit | ~owner_keep | (expired & others_wait & ~owner_locked));
    assign host_release = host_active & ~host_req;
    assign bus_free     = (state_q.own == OWN_NONE) | peer_release | host_release;

    assign next_after   = (state_q.owner == LAST_IDX) ? '0 : state_q.owner + IW'(1);
    assign pick_start   = peer_release ? next_after : state_q.ptr;
    assign cand         = peer_req & ~(peer_release ? owner_oh : '0);
    assign host_wins    = host_req & (HOST_FIRST | boff_hit | ~(|cand));
    assign restart      = bus_free & ~host_wins & found;
    assign hold         = peer_active & ~peer_release;

    bus_arb_rr_pick #(.N(NUM_PEERS), .IW(IW)) u_pick (
        .cand  (cand),
        .start (pick_start),
        .sel   (sel),
        .found (found)
    );

    bus_arb_tenure #(.TW(TENURE_W)) u_tenure (
        .cnt_q   (state_q.cnt),
        .limit   (tenure_limit),
        .restart (restart),
        .hold    (hold),
        .cnt_d   (cnt_d),
        .expired (expired)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_d;
        if (peer_release)
            state_d.ptr = next_after;
        if (bus_free) begin
            if (host_wins) begin
                state_d.own = OWN_HOST;
            end else if (found) begin
                state_d.own   = OWN_PEER;
                state_d.owner = sel;
            end else begin
                state_d.own = OWN_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.own   <= OWN_NONE;
            state_q.owner <= '0;
            state_q.ptr   <= '0;
            state_q.cnt   <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        peer_gnt = '0;
        if (peer_active)
            peer_gnt[state_q.owner] = 1'b1;
    end
    assign host_gnt = host_active;

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_gnt, peer_gnt}));

    assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_gnt & ~$past(peer_gnt) & ~$past(peer_req)) == '0);

    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(peer_gnt & peer_lock)) && !(host_boff && host_req)) |=> $stable(peer_gnt));

    assert_host_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_gnt) |-> $past(host_req));

    assert_backoff_takes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_boff && host_req && (|peer_gnt)) |=> host_gnt);
endmodule

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] peer_req = '0, peer_lock = '0;
    logic       host_req = 1'b0, host_boff = 1'b0;
    logic [7:0] tenure_limit = '0;
    logic [7:0] peer_gnt;
    logic       host_gnt;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] pg;
        logic       hg;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .peer_req(peer_req), .peer_lock(peer_lock),
        .host_req(host_req), .host_boff(host_boff), .tenure_limit(tenure_limit),
        .peer_gnt(peer_gnt), .host_gnt(host_gnt)
    );

    task automatic step(input logic [7:0] r, input logic [7:0] l, input logic h,
                        input logic b, input logic [7:0] epg, input logic ehg,
                        input string tag);
        @(posedge clk);
        #5;
        peer_req  = r;
        peer_lock = l;
        host_req  = h;
        host_boff = b;
        exp_q.push_back('{pg: epg, hg: ehg, tag: tag});
    endtask

    // Monitor: compares each result one edge after its stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (rst_n && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (peer_gnt !== e.pg || host_gnt !== e.hg) begin
                    errors++;
                    $display("FAIL %s: peer_gnt=%h host_gnt=%b expected peer_gnt=%h host_gnt=%b",
                             e.tag, peer_gnt, host_gnt, e.pg, e.hg);
                end
                checks++;
                if ($countones({host_gnt, peer_gnt}) > 1) begin
                    errors++;
                    $display("FAIL R2: grants=%b expected at most one high", {host_gnt, peer_gnt});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        checks++;
        if (peer_gnt !== 8'h00 || host_gnt !== 1'b0) begin
            errors++;
            $display("FAIL R1: in reset peer_gnt=%h host_gnt=%b expected 00/0", peer_gnt, host_gnt);
        end
        #2;
        rst_n = 1'b1;

        // R1: idle, then pointer starts at peer 0
        step(8'h00, 8'h00, 0, 0, 8'h00, 0, "R1 idle after reset");
        step(8'hFF, 8'h00, 0, 0, 8'h01, 0, "R1 first pick peer0");
        // R7: limit 0, owner never cut off
        for (int i = 0; i < 6; i++)
            step(8'hFF, 8'h00, 0, 0, 8'h01, 0, "R7 cap disabled");
        // R4/R13 rotation and same-edge handover
        step(8'hFE, 8'h00, 0, 0, 8'h02, 0, "R13 handover to peer1");
        step(8'hFC, 8'h00, 0, 0, 8'h04, 0, "R4 rotate to peer2");
        step(8'h05, 8'h00, 0, 0, 8'h04, 0, "R5 owner holds");
        step(8'h01, 8'h00, 0, 0, 8'h01, 0, "R4 wrap to peer0");
        step(8'h00, 8'h00, 0, 0, 8'h00, 0, "R3 nobody requests");
        step(8'h80, 8'h00, 0, 0, 8'h80, 0, "R3 top peer7");
        step(8'h81, 8'h00, 0, 0, 8'h80, 0, "R5 peer7 holds");
        step(8'h01, 8'h00, 0, 0, 8'h01, 0, "R4 wrap 7 to 0");
        step(8'h00, 8'h00, 0, 0, 8'h00, 0, "R3 release");
        // R5 lock keeps ownership
        step(8'h02, 8'h00, 0, 0, 8'h02, 0, "R5 grant peer1");
        step(8'h00, 8'h02, 0, 0, 8'h02, 0, "R5 lock alone keeps");
        step(8'h10, 8'h02, 0, 0, 8'h02, 0, "R5 lock blocks peer4");
        step(8'h10, 8'h00, 0, 0, 8'h10, 0, "R5 release to peer4");
        step(8'h00, 8'h00, 0, 0, 8'h00, 0, "R3 idle");

        // R8 / R6 fairness cap of 4
        tenure_limit = 8'd4;
        step(8'h08, 8'h00, 0, 0, 8'h08, 0, "R4 search from 5 finds peer3");
        for (int i = 0; i < 5; i++)
            step(8'h08, 8'h00, 0, 0, 8'h08, 0, "R8 no waiter no cut");
        step(8'h48, 8'h00, 0, 0, 8'h40, 0, "R6 expired owner yields");
        for (int i = 0; i < 3; i++)
            step(8'h48, 8'h00, 0, 0, 8'h40, 0, "R6 within tenure");
        step(8'h48, 8'h00, 0, 0, 8'h08, 0, "R6 cut after exactly 4");
        // R9 lock defeats the cap
        for (int i = 0; i < 6; i++)
            step(8'h48, 8'h08, 0, 0, 8'h08, 0, "R9 locked owner kept");
        step(8'h48, 8'h00, 0, 0, 8'h40, 0, "R9 unlock then cut");
        step(8'h00, 8'h00, 0, 0, 8'h00, 0, "R3 idle");

        // R10 host waits for tenure end, then wins
        step(8'h01, 8'h00, 0, 0, 8'h01, 0, "R4 peer0 granted");
        for (int i = 0; i < 3; i++)
            step(8'h01, 8'h00, 1, 0, 8'h01, 0, "R10 host waits for tenure");
        step(8'h01, 8'h00, 1, 0, 8'h00, 1, "R10 host granted at tenure end");
        for (int i = 0; i < 6; i++)
            step(8'h06, 8'h00, 1, 0, 8'h00, 1, "R10 host not capped");
        step(8'h06, 8'h00, 0, 0, 8'h02, 0, "R12 rotation resumes at peer1");
        step(8'h00, 8'h00, 0, 0, 8'h00, 0, "R3 idle");
        step(8'h10, 8'h00, 1, 0, 8'h00, 1, "R10 host beats peer from idle");
        step(8'h10, 8'h00, 0, 0, 8'h10, 0, "R13 host to peer4");

        // R11 back-off beats lock
        for (int i = 0; i < 4; i++)
            step(8'h10, 8'h10, 1, 0, 8'h10, 0, "R9 locked peer keeps vs host");
        step(8'h10, 8'h10, 1, 1, 8'h00, 1, "R11 back-off grants host");
        step(8'h00, 8'h00, 0, 0, 8'h00, 0, "R3 all released");

        repeat (3) @(posedge clk);
        #4;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3: %0d results never compared, expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule